// File: doc/BRIEF.md
# Pattern-Driven Memory Waveform Sequencer

This block drives the control pins of an external memory from a small writable pattern store. Each stored word describes one clock cycle. It gives the level of eight active-low byte-select lines and six active-low general-purpose lines for that cycle. It also says whether the row or the column half of the access address goes out on the multiplexed address pins, whether the burst beat counter advances, and whether transfer acknowledge is raised. Because the waveforms come from stored words and not from fixed logic, one block can serve SRAM-like parts, multiplexed-address DRAM and other peripherals.

Software fills the store through a write-only configuration port made of an address, a data word and a write strobe. When an access request arrives while the block is idle, the request's direction (read or write) and size (single or burst) pick a fixed entry word. The sequencer then plays one word per clock until it reaches a word whose end flag is set. While no pattern plays, every control line rests at its inactive level.

Top module: `mem_wave_seq`

## Requirements
- R1: While idle (busy low), and out of reset, all `bs_n` and `gpl_n` bits are 1, `xfer_ack` is 0 and `mem_addr` is 0. After reset every stored word has the end flag set and all line bits at 1.
- R2: With busy low, a pulse on `cfg_we` writes `cfg_wdata` into word `cfg_addr`. The word takes effect from the next clock, even when a pattern starts in the same cycle as the write. Word layout: bit 17 end, bit 16 acknowledge, bit 15 increment, bit 14 address select (1 = column), bits 13:8 general-purpose lines, bits 7:0 byte selects.
- R3: A `cfg_we` pulse while busy is high changes no stored word.
- R4: The first word played is word 0 for a single read, word 8 for a burst read, word 24 for a single write and word 32 for a burst write (`acc_write` = 1 means write, `acc_burst` = 1 means burst).
- R5: While busy, `bs_n` and `gpl_n` equal the fields of the current word, and the word index advances by one each clock.
- R6: While busy, `mem_addr` is `acc_addr[15:8]` (row) when the address-select bit is 0. When that bit is 1, it is `{acc_addr[7:2], beat}` (column), with the address captured at start.
- R7: The beat starts at `acc_addr[1:0]`. It gains one at each clock edge that ends a word with the increment bit set, and wraps modulo 4. Otherwise it holds.
- R8: While busy, `xfer_ack` equals the current word's acknowledge bit.
- R9: After a word with the end flag set, busy is low on the next clock.
- R10: `acc_start` while busy is ignored. The running pattern continues unchanged.
- R11: `acc_start` sampled high with busy low makes busy high and plays the entry word from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Pattern store write strobe |
| cfg_addr | input | 6 | Pattern store word index |
| cfg_wdata | input | 18 | Pattern word to store |
| acc_start | input | 1 | Access request |
| acc_write | input | 1 | Request direction, 1 = write |
| acc_burst | input | 1 | Request size, 1 = burst |
| acc_addr | input | 16 | Access address, row in upper byte, column in lower byte |
| mem_addr | output | 8 | Multiplexed row/column address |
| bs_n | output | 8 | Active-low byte selects |
| gpl_n | output | 6 | Active-low general-purpose lines |
| xfer_ack | output | 1 | Transfer acknowledge |
| busy | output | 1 | Pattern in progress |

## Verification
Two pairs of functions can coincide in a cycle. The first is a store write and a pattern start. The bench writes entry word 0 in the same cycle that it requests a single read, and expects the new byte selects in the first played cycle. It also writes a word during a running pattern and expects the old contents on the next run. The second pair is an increment and an end flag in the same word. It is provoked by a burst whose last word advances the beat, judged by busy falling and by the beat carried into the next wrapped column. A behavioural model compares every output on every clock.

// File: rtl/mws_pkg.sv
package mws_pkg;

    parameter int BS_W     = 8;
    parameter int GPL_W    = 6;
    parameter int PAT_DEPTH = 64;
    parameter int PC_W     = $clog2(PAT_DEPTH);
    parameter int MA_W     = 8;
    parameter int BEAT_W   = 2;
    parameter int ACC_AW   = 2 * MA_W;

    typedef struct packed {
        logic             last;
        logic             ack;
        logic             inc;
        logic             amux;
        logic [GPL_W-1:0] gpl;
        logic [BS_W-1:0]  bs;
    } pat_word_t;

    parameter int WORD_W = $bits(pat_word_t);

    typedef enum logic [1:0] {
        ACC_RD_SINGLE = 2'b00,
        ACC_RD_BURST  = 2'b01,
        ACC_WR_SINGLE = 2'b10,
        ACC_WR_BURST  = 2'b11
    } acc_kind_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    parameter logic [PC_W-1:0] ENTRY_RD_SINGLE = PC_W'(0);
    parameter logic [PC_W-1:0] ENTRY_RD_BURST  = PC_W'(8);
    parameter logic [PC_W-1:0] ENTRY_WR_SINGLE = PC_W'(24);
    parameter logic [PC_W-1:0] ENTRY_WR_BURST  = PC_W'(32);

    function automatic logic [PC_W-1:0] entry_of(input acc_kind_t kind);
        case (kind)
            ACC_RD_SINGLE: return ENTRY_RD_SINGLE;
            ACC_RD_BURST:  return ENTRY_RD_BURST;
            ACC_WR_SINGLE: return ENTRY_WR_SINGLE;
            default:       return ENTRY_WR_BURST;
        endcase
    endfunction

    function automatic pat_word_t idle_word();
        pat_word_t w;
        w.last = 1'b1;
        w.ack  = 1'b0;
        w.inc  = 1'b0;
        w.amux = 1'b0;
        w.gpl  = '1;
        w.bs   = '1;
        return w;
    endfunction

endpackage

// File: rtl/mws_pattern_ram.sv
module mws_pattern_ram
    import mws_pkg::*;
#(
    parameter int DEPTH_P = PAT_DEPTH,
    localparam int AW = $clog2(DEPTH_P)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  logic      lock,
    input  logic [AW-1:0] waddr,
    input  pat_word_t wdata,
    input  logic [AW-1:0] raddr,
    output pat_word_t rdata
);

    pat_word_t mem [DEPTH_P];

    generate
        for (genvar i = 0; i < DEPTH_P; i++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[i] <= idle_word();
                end else if (we && !lock && (waddr == AW'(i))) begin
                    mem[i] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = mem[raddr];

endmodule

// File: rtl/mws_sequencer.sv
module mws_sequencer
    import mws_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  acc_kind_t       kind,
    input  logic            word_last,
    output logic [PC_W-1:0] pc,
    output logic            busy,
    output logic            capture
);

    seq_state_t state_q;
    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            pc_q    <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_RUN;
                        pc_q    <= entry_of(kind);
                    end
                end
                default: begin
                    if (word_last) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        pc_q <= pc_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy    = (state_q == SEQ_RUN);
    assign capture = (state_q == SEQ_IDLE) && start;
    assign pc      = pc_q;

endmodule

// File: rtl/mws_addr_gen.sv
module mws_addr_gen
    import mws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              busy,
    input  logic              inc,
    input  logic              amux,
    input  logic [ACC_AW-1:0] addr_in,
    output logic [MA_W-1:0]   mem_addr,
    output logic [BEAT_W-1:0] beat_o
);

    logic [MA_W-1:0]        row_q;
    logic [MA_W-BEAT_W-1:0] col_hi_q;
    logic [BEAT_W-1:0]      beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q    <= '0;
            col_hi_q <= '0;
            beat_q   <= '0;
        end else if (capture) begin
            row_q    <= addr_in[ACC_AW-1:MA_W];
            col_hi_q <= addr_in[MA_W-1:BEAT_W];
            beat_q   <= addr_in[BEAT_W-1:0];
        end else if (busy && inc) begin
            beat_q   <= beat_q + 1'b1;
        end
    end

    always_comb begin
        if (!busy) begin
            mem_addr = '0;
        end else if (amux) begin
            mem_addr = {col_hi_q, beat_q};
        end else begin
            mem_addr = row_q;
        end
    end

    assign beat_o = beat_q;

endmodule

// File: rtl/mem_wave_seq.sv
module mem_wave_seq
    import mws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [PC_W-1:0]   cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              acc_start,
    input  logic              acc_write,
    input  logic              acc_burst,
    input  logic [ACC_AW-1:0] acc_addr,
    output logic [MA_W-1:0]   mem_addr,
    output logic [BS_W-1:0]   bs_n,
    output logic [GPL_W-1:0]  gpl_n,
    output logic              xfer_ack,
    output logic              busy
);

    pat_word_t         cur_word;
    logic [PC_W-1:0]   seq_pc;
    logic              seq_busy;
    logic              seq_capture;
    logic [BEAT_W-1:0] beat;
    acc_kind_t         kind;

    assign kind = acc_kind_t'({acc_write, acc_burst});

    mws_pattern_ram #(.DEPTH_P(PAT_DEPTH)) ram_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .lock  (seq_busy),
        .waddr (cfg_addr),
        .wdata (pat_word_t'(cfg_wdata)),
        .raddr (seq_pc),
        .rdata (cur_word)
    );

    mws_sequencer seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (acc_start),
        .kind      (kind),
        .word_last (cur_word.last),
        .pc        (seq_pc),
        .busy      (seq_busy),
        .capture   (seq_capture)
    );

    mws_addr_gen addr_i (
        .clk      (clk),
        .rst      (rst),
        .capture  (seq_capture),
        .busy     (seq_busy),
        .inc      (cur_word.inc),
        .amux     (cur_word.amux),
        .addr_in  (acc_addr),
        .mem_addr (mem_addr),
        .beat_o   (beat)
    );

    assign bs_n     = seq_busy ? cur_word.bs  : '1;
    assign gpl_n    = seq_busy ? cur_word.gpl : '1;
    assign xfer_ack = seq_busy & cur_word.ack;
    assign busy     = seq_busy;

endmodule

// File: rtl/mws_checker.sv
module mws_checker
    import mws_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              acc_start,
    input logic [PC_W-1:0]   pc,
    input logic              word_last,
    input logic              word_inc,
    input logic [BEAT_W-1:0] beat,
    input logic [BS_W-1:0]   bs_n,
    input logic [GPL_W-1:0]  gpl_n,
    input logic              xfer_ack,
    input logic [MA_W-1:0]   mem_addr
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ((&bs_n) && (&gpl_n) && !xfer_ack && (mem_addr == '0))); // R1

    AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
        (!busy && acc_start) |=> busy); // R11

    AST_LAST_STOPS: assert property (@(posedge clk) disable iff (rst)
        (busy && word_last) |=> !busy); // R9

    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (busy && !word_last) |=> (busy && (pc == $past(pc) + 1'b1))); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && !word_last && acc_start) |=> (pc == $past(pc) + 1'b1)); // R10

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && word_inc) |=> (beat == $past(beat) + 1'b1)); // R7

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !word_inc) |=> $stable(beat)); // R7

endmodule

bind mem_wave_seq mws_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .acc_start (acc_start),
    .pc        (seq_pc),
    .word_last (cur_word.last),
    .word_inc  (cur_word.inc),
    .beat      (beat),
    .bs_n      (bs_n),
    .gpl_n     (gpl_n),
    .xfer_ack  (xfer_ack),
    .mem_addr  (mem_addr)
);

// File: tb/mem_wave_seq_tb_top.sv
`timescale 1ns/1ps
module mem_wave_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [17:0] cfg_wdata = '0;
    logic        acc_start = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_burst = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  mem_addr;
    logic [7:0]  bs_n;
    logic [5:0]  gpl_n;
    logic        xfer_ack;
    logic        busy;

    int checks = 0;
    int fails = 0;
    int wd = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mem_wave_seq dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_start(acc_start), .acc_write(acc_write),
        .acc_burst(acc_burst), .acc_addr(acc_addr), .mem_addr(mem_addr),
        .bs_n(bs_n), .gpl_n(gpl_n), .xfer_ack(xfer_ack), .busy(busy)
    );

    // behavioural reference state
    logic [17:0] mram [64];
    logic        m_busy;
    int          m_pc;
    logic [7:0]  m_row;
    logic [5:0]  m_colhi;
    int          m_beat;

    // per-run log of observed outputs, index 0 = request cycle
    logic [7:0] log_bs   [32];
    logic [5:0] log_gpl  [32];
    logic [7:0] log_addr [32];
    logic       log_ack  [32];
    logic       log_busy [32];
    int li = 0;

    function automatic logic [17:0] mk(input logic last, ack, inc, amux,
                                       input logic [5:0] gpl, input logic [7:0] bs);
        return {last, ack, inc, amux, gpl, bs};
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) mram[i] = mk(1'b1, 1'b0, 1'b0, 1'b0, 6'h3F, 8'hFF);
        m_busy = 0; m_pc = 0; m_row = 0; m_colhi = 0; m_beat = 0;
    endtask

    task automatic compare();
        logic [17:0] w;
        if (m_busy) begin
            w = mram[m_pc];
            chk("R5", "bs_n", 32'(bs_n), 32'(w[7:0]));
            chk("R5", "gpl_n", 32'(gpl_n), 32'(w[13:8]));
            chk("R8", "xfer_ack", 32'(xfer_ack), 32'(w[16]));
            chk("R6", "mem_addr", 32'(mem_addr),
                w[14] ? 32'({m_colhi, 2'(m_beat)}) : 32'(m_row));
            chk("R9", "busy", 32'(busy), 32'd1);
        end else begin
            chk("R1", "bs_n", 32'(bs_n), 32'hFF);
            chk("R1", "gpl_n", 32'(gpl_n), 32'h3F);
            chk("R1", "xfer_ack", 32'(xfer_ack), 32'd0);
            chk("R1", "mem_addr", 32'(mem_addr), 32'd0);
            chk("R9", "busy", 32'(busy), 32'd0);
        end
    endtask

    task automatic cycle(input logic st, wr, bu, input logic [15:0] ad,
                         input logic we, input logic [5:0] wa, input logic [17:0] wd_in);
        logic [17:0] w;
        @(negedge clk);
        compare();
        if (li < 32) begin
            log_bs[li] = bs_n; log_gpl[li] = gpl_n; log_addr[li] = mem_addr;
            log_ack[li] = xfer_ack; log_busy[li] = busy;
        end
        li++;
        acc_start = st; acc_write = wr; acc_burst = bu; acc_addr = ad;
        cfg_we = we; cfg_addr = wa; cfg_wdata = wd_in;
        if (!m_busy) begin
            if (we) mram[wa] = wd_in;
            if (st) begin
                m_busy = 1;
                m_pc = wr ? (bu ? 32 : 24) : (bu ? 8 : 0);
                m_row = ad[15:8]; m_colhi = ad[7:2]; m_beat = int'(ad[1:0]);
            end
        end else begin
            w = mram[m_pc];
            if (w[15]) m_beat = (m_beat + 1) % 4;
            if (w[17]) m_busy = 0;
            else m_pc = (m_pc + 1) % 64;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 16'h0, 0, 6'h0, 18'h0);
    endtask

    task automatic load(input logic [5:0] a, input logic [17:0] d);
        cycle(0, 0, 0, 16'h0, 1, a, d);
    endtask

    task automatic run(input logic wr, bu, input logic [15:0] ad, input int n, input logic hold);
        li = 0;
        cycle(1, wr, bu, ad, 0, 6'h0, 18'h0);
        for (int i = 0; i < n; i++) cycle(hold, wr, bu, ad, 0, 6'h0, 18'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(3); // R1 reset state

        // R2: program patterns while idle
        load(6'd0,  mk(0, 0, 0, 0, 6'h3E, 8'h00));
        load(6'd1,  mk(0, 1, 0, 1, 6'h3D, 8'h00));
        load(6'd2,  mk(1, 0, 0, 0, 6'h3F, 8'hFF));
        load(6'd8,  mk(0, 0, 0, 0, 6'h3E, 8'h00));
        for (int a = 9; a < 12; a++) load(6'(a), mk(0, 1, 1, 1, 6'h3C, 8'h00));
        load(6'd12, mk(1, 1, 1, 1, 6'h3C, 8'h00));
        load(6'd24, mk(0, 0, 0, 0, 6'h3B, 8'hF0));
        load(6'd25, mk(1, 1, 0, 1, 6'h37, 8'h0F));
        load(6'd32, mk(0, 0, 0, 0, 6'h2F, 8'h55));
        for (int a = 33; a < 36; a++) load(6'(a), mk(0, 1, 1, 1, 6'h1F, 8'hAA));
        load(6'd36, mk(1, 1, 1, 1, 6'h1F, 8'hA5));

        // single read: row then column with acknowledge
        run(0, 0, 16'hC32A, 4, 0);
        chk("R4", "single read entry gpl", 32'(log_gpl[1]), 32'h3E);
        chk("R11", "busy after start", 32'(log_busy[1]), 32'd1);
        chk("R6", "row out", 32'(log_addr[1]), 32'hC3);
        chk("R6", "column out", 32'(log_addr[2]), 32'h2A);
        chk("R8", "ack on column word", 32'(log_ack[2]), 32'd1);
        chk("R9", "busy after end", 32'(log_busy[4]), 32'd0);

        // burst read with beat starting at 3: wraps to 0
        run(0, 1, 16'h5A07, 7, 0);
        chk("R4", "burst read entry gpl", 32'(log_gpl[1]), 32'h3E);
        chk("R7", "first beat", 32'(log_addr[2]), 32'h07);
        chk("R7", "wrapped beat", 32'(log_addr[3]), 32'h04);
        chk("R7", "last beat", 32'(log_addr[5]), 32'h06);
        chk("R9", "idle after inc+end word", 32'(log_busy[6]), 32'd0);

        // single write; a load during the run must be ignored
        li = 0;
        cycle(1, 1, 0, 16'h1234, 0, 6'h0, 18'h0);
        cycle(0, 1, 0, 16'h1234, 1, 6'd25, mk(1, 0, 0, 0, 6'h00, 8'h3C));
        idle(3);
        chk("R4", "single write entry bs", 32'(log_bs[1]), 32'hF0);
        run(1, 0, 16'h1234, 3, 0);
        chk("R3", "word kept after busy load", 32'(log_bs[2]), 32'h0F);
        chk("R8", "write ack", 32'(log_ack[2]), 32'd1);

        // burst write with request held high throughout
        run(1, 1, 16'hFFFE, 8, 1);
        chk("R4", "burst write entry bs", 32'(log_bs[1]), 32'h55);
        chk("R10", "pattern unchanged by held start", 32'(log_bs[5]), 32'hA5);
        chk("R10", "beat wrap under held start", 32'(log_addr[4]), 32'hFC);
        chk("R9", "idle gap", 32'(log_busy[6]), 32'd0);
        chk("R11", "restart entry bs", 32'(log_bs[7]), 32'h55);
        idle(8);

        // same-cycle load of entry word and start
        li = 0;
        cycle(1, 0, 0, 16'h0102, 1, 6'd0, mk(0, 0, 0, 0, 6'h2A, 8'h81));
        idle(4);
        chk("R2", "new entry word on first cycle", 32'(log_bs[1]), 32'h81);
        chk("R2", "new entry gpl", 32'(log_gpl[1]), 32'h2A);
        idle(2);

        finish_run();
    end

endmodule